// File: doc/BRIEF.md
# GPIO Interrupt Trigger Detector

This block watches a set of general-purpose input pins and raises a separate interrupt request for each one when that pin meets its programmed trigger condition. Each pin has a 3-bit style field. The style can make the pin fire on a high level, on a low level, on a rising edge, on a falling edge or on any transition. The remaining codes switch the pin off. The style fields are packed eight to a bank register, so the default sixteen pins use two banks.

Inputs are asynchronous to the block clock, so each one passes through a two-flop synchronizer. Edges are found by comparing the synchronized value with the value it had one cycle earlier. A detected condition sets a sticky pending bit. Software clears that bit by writing a one to it. A level-style pin keeps setting its bit again for as long as its level holds, so software must remove the cause before it acknowledges the interrupt. When software changes a pin's style, it should write the new field, clear the pin's pending bit and then rely on the new style alone.

Registers are reached through a simple single-cycle write strobe and a combinational read port. The bank registers sit at addresses 0 and 1, and the pending register sits at the address just after the last bank (address 2 by default).

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, every style field reads 0, every pending bit reads 0 and every irqOut line is low.
- R2: Style code 0 (level high) sets pin p's pending bit on the third rising clock edge after the pin goes high. It is not set after the first or second edge.
- R3: Style code 1 (level low) sets the pending bit while the synchronized pin is low.
- R4: Style code 2 (rising) sets the pending bit when the synchronized pin changes from 0 to 1.
- R5: Style code 3 (falling) sets the pending bit when the synchronized pin changes from 1 to 0.
- R6: Style code 4 (any transition) sets the pending bit on both rising and falling changes of the synchronized pin.
- R7: Style codes 5, 6 and 7 never set the pending bit, whatever the pin does.
- R8: Pin p's style field sits in bank register p/8 (address 0 or 1), in bits [3*(p%8)+2 : 3*(p%8)]. Register bits 31:24 read as 0.
- R9: Writing pending register address 2 clears every bit written as 1. Bits written as 0 keep their value.
- R10: A level-style pin whose condition still holds reads as pending again right after it is cleared.
- R11: When a trigger condition and a clear hit the same bit in the same cycle, the bit ends up set.
- R12: irqOut[p] equals pending bit p, which reads back in bits 15:0 of address 2. Bits 31:16 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | NUM_PINS | Asynchronous general-purpose input pins |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | ADDR_W | Register address for reads and writes |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Combinational read data for regAddr |
| irqOut | output | NUM_PINS | Per-pin interrupt requests |

## Verification
The bench rotates all eight style codes over all sixteen pins and pairs each rotation with several before/after input vectors. This finds a swapped style decode, or a field at the wrong bit offset, because the wrong pins would latch. A directed latency test catches a synchronizer with one flop too few or too many, since the pending bit would then appear a cycle early or late. A test in which a clear lands on the same edge as a new event catches a design where the clear wins, because the event would be lost. Clearing an active level-high pin catches a design that drops a level pin's request while its condition still holds.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Width of one per-pin trigger style field
  localparam int STYLE_W = 3;
  // Upper bound on style banks the strobe struct can carry
  localparam int MAX_BANKS = 4;

  localparam logic [STYLE_W-1:0] STY_HIGH = 3'd0;
  localparam logic [STYLE_W-1:0] STY_LOW  = 3'd1;
  localparam logic [STYLE_W-1:0] STY_RISE = 3'd2;
  localparam logic [STYLE_W-1:0] STY_FALL = 3'd3;
  localparam logic [STYLE_W-1:0] STY_ANY  = 3'd4;

  // Strobes from register decode to the datapath
  typedef struct packed {
    logic [MAX_BANKS-1:0] bankWr;
    logic                 statusClr;
  } regStrobe_t;

  // Condition for one pin given its style, current and previous sample
  function automatic logic styleHit(logic [STYLE_W-1:0] sty, logic cur, logic prev);
    case (sty)
      STY_HIGH: styleHit = cur;
      STY_LOW:  styleHit = !cur;
      STY_RISE: styleHit = cur && !prev;
      STY_FALL: styleHit = !cur && prev;
      STY_ANY:  styleHit = cur ^ prev;
      default:  styleHit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(NUM_BANKS);

  always_comb begin
    strobe = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      strobe.bankWr[b] = regWrEn && (regAddr == ADDR_W'(b));
    end
    strobe.statusClr = regWrEn && (regAddr == STATUS_ADDR);
  end

  // R9 a single write touches at most one register
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.bankWr, strobe.statusClr}));

  // R9 no strobe fires without a write request
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |-> (strobe == '0));

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS      = 16,
  parameter int PINS_PER_BANK = 8,
  parameter int ADDR_W        = 2,
  parameter int DATA_W        = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  regStrobe_t          strobe,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [DATA_W-1:0]   rdData,
  output logic [NUM_PINS-1:0] statusQ
);

  localparam int NUM_BANKS  = NUM_PINS / PINS_PER_BANK;
  localparam int FIELD_BITS = PINS_PER_BANK * STYLE_W;
  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(NUM_BANKS);

  logic [NUM_PINS-1:0]   syncA, syncB, prevB;
  logic [NUM_PINS-1:0]   setMask, clrMask;
  logic [FIELD_BITS-1:0] bankQ [NUM_BANKS];

  logic unusedBits;
  assign unusedBits = ^{wrData[DATA_W-1:FIELD_BITS], strobe.bankWr[MAX_BANKS-1:NUM_BANKS]};

  // Two-flop synchronizer plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  // Style bank registers
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bankQ[b] <= '0;
      end else if (strobe.bankWr[b]) begin
        bankQ[b] <= wrData[FIELD_BITS-1:0];
      end
    end
  end

  // Per-pin trigger detection
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [STYLE_W-1:0] pinStyle;
    assign pinStyle   = bankQ[p / PINS_PER_BANK][(p % PINS_PER_BANK) * STYLE_W +: STYLE_W];
    assign setMask[p] = styleHit(pinStyle, syncB[p], prevB[p]);

    // R7 a disabled code leaves a clear pending bit clear
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pinStyle > STY_ANY && !statusQ[p]) |=> !statusQ[p]);

    // R10 level high held means pending next cycle, clear or not
    level_reassert_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pinStyle == STY_HIGH && syncB[p]) |=> statusQ[p]);

    // R11 a detected event is never lost to a same-cycle clear
    set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      setMask[p] |=> statusQ[p]);

    // R9 a one written with no event clears the bit
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (clrMask[p] && !setMask[p]) |=> !statusQ[p]);

    // R9 a pending bit not written as one stays pending
    w1c_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (statusQ[p] && !clrMask[p]) |=> statusQ[p]);
  end

  assign clrMask = strobe.statusClr ? wrData[NUM_PINS-1:0] : '0;

  // Pending register: write-one-to-clear, set has priority
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
    end else begin
      statusQ <= (statusQ & ~clrMask) | setMask;
    end
  end

  // Read mux
  always_comb begin
    rdData = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (rdAddr == ADDR_W'(b)) rdData[FIELD_BITS-1:0] = bankQ[b];
    end
    if (rdAddr == STATUS_ADDR) rdData[NUM_PINS-1:0] = statusQ;
  end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS      = 16,
  parameter int PINS_PER_BANK = 8,
  parameter int ADDR_W        = 2,
  parameter int DATA_W        = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  output logic [NUM_PINS-1:0] irqOut
);

  localparam int NUM_BANKS = NUM_PINS / PINS_PER_BANK;

  regStrobe_t          strobe;
  logic [NUM_PINS-1:0] statusQ;

  gpio_irq_ctrl #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  gpio_irq_datapath #(
    .NUM_PINS      (NUM_PINS),
    .PINS_PER_BANK (PINS_PER_BANK),
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .strobe  (strobe),
    .wrData  (regWrData),
    .rdAddr  (regAddr),
    .rdData  (regRdData),
    .statusQ (statusQ)
  );

  assign irqOut = statusQ;

endmodule

// File: tb/gpio_irq_detect_test.sv
module gpio_irq_detect_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] pinIn;
  logic        regWrEn;
  logic [1:0]  regAddr;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic [15:0] irqOut;

  int checks = 0;
  int fails  = 0;
  logic [2:0] styArr [16];

  always #2.5 clk = ~clk;

  gpio_irq_detect uut (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (pinIn),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .irqOut    (irqOut)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  task automatic loadStyles();
    logic [31:0] v0, v1;
    v0 = '0; v1 = '0;
    for (int p = 0; p < 8; p++) begin
      v0[3*p +: 3] = styArr[p];
      v1[3*p +: 3] = styArr[p+8];
    end
    wr(2'd0, v0);
    wr(2'd1, v1);
  endtask

  function automatic logic hit(logic [2:0] s, logic o, logic n);
    case (s)
      3'd0: return n;
      3'd1: return !n;
      3'd2: return n && !o;
      3'd3: return o && !n;
      3'd4: return o ^ n;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] expVec(logic [15:0] o, logic [15:0] n);
    logic [15:0] r;
    for (int p = 0; p < 16; p++) r[p] = hit(styArr[p], o[p], n[p]);
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [15:0] v0List [6];
    logic [15:0] v1List [6];
    logic [15:0] base, expS;

    rstN = 1'b0; pinIn = '0; regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irqOut", {16'h0, irqOut}, 32'h0);
    rd(2'd0, d); check("R1 bank0", d, 32'h0);
    rd(2'd1, d); check("R1 bank1", d, 32'h0);
    rd(2'd2, d); check("R1 pending", d, 32'h0);
    rstN = 1'b1;

    // R8 field placement, using disabled code 5
    for (int p = 0; p < 16; p++) begin
      logic [31:0] expB;
      expB = 32'h0;
      expB[3*(p%8) +: 3] = 3'd5;
      wr(p < 8 ? 2'd0 : 2'd1, expB);
      rd(p < 8 ? 2'd0 : 2'd1, d); check("R8 own bank", d, expB);
      rd(p < 8 ? 2'd1 : 2'd0, d); check("R8 other bank", d, 32'h0);
      wr(p < 8 ? 2'd0 : 2'd1, 32'h0);
    end
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); check("R8 upper bits zero", d, 32'h00FF_FFFF);

    // R2 latency: pin 2 level high, others disabled
    for (int p = 0; p < 16; p++) styArr[p] = 3'd7;
    styArr[2] = 3'd0;
    loadStyles();
    wr(2'd2, 32'hFFFF);
    pinIn[2] = 1'b1;
    @(negedge clk); check("R2 after edge 1", {16'h0, irqOut}, 32'h0);
    @(negedge clk); check("R2 after edge 2", {16'h0, irqOut}, 32'h0);
    @(negedge clk); check("R2 after edge 3", {16'h0, irqOut}, 32'h4);
    // R10 clear while the level holds
    wr(2'd2, 32'h4);
    rd(2'd2, d); check("R10 reasserts", d, 32'h4);
    pinIn[2] = 1'b0;
    repeat (3) @(negedge clk);
    wr(2'd2, 32'h4);
    rd(2'd2, d); check("R9 clears once idle", d, 32'h0);

    // R11 set against clear on the same edge: pins 0 and 1 rising
    styArr[0] = 3'd2; styArr[1] = 3'd2; styArr[2] = 3'd7;
    loadStyles();
    wr(2'd2, 32'hFFFF);
    pinIn[1] = 1'b1;
    repeat (4) @(negedge clk);
    check("R4 pin1 rising", {16'h0, irqOut}, 32'h2);
    pinIn[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 2'd2; regWrData = 32'hFFFF;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
    check("R11 set wins", {16'h0, irqOut}, 32'h1);
    pinIn = '0;
    repeat (4) @(negedge clk);
    wr(2'd2, 32'hFFFF);

    // Sweep: every style on every pin, several vector pairs
    v0List = '{16'h0000, 16'hFFFF, 16'hA5A5, 16'h0F0F, 16'h1234, 16'h8001};
    v1List = '{16'hFFFF, 16'h0000, 16'h5A3C, 16'hF0F0, 16'h1234, 16'h7FFE};
    for (int rot = 0; rot < 8; rot++) begin
      for (int p = 0; p < 16; p++) styArr[p] = 3'((p + rot) % 8);
      loadStyles();
      for (int k = 0; k < 6; k++) begin
        pinIn = v0List[k];
        repeat (5) @(negedge clk);
        wr(2'd2, 32'hFFFF);
        base = expVec(v0List[k], v0List[k]);
        rd(2'd2, d);
        // R3 R10 levels re-assert after clear, edges stay clear
        check("R3 R10 post-clear", d, {16'h0, base});
        pinIn = v1List[k];
        repeat (4) @(negedge clk);
        expS = base | expVec(v0List[k], v1List[k]);
        // R2 R3 R4 R5 R6 R7 detection per style
        check("R2 R3 R4 R5 R6 R7 sweep", {16'h0, irqOut}, {16'h0, expS});
        wr(2'd2, 32'h0);
        rd(2'd2, d);
        // R9 R12 zero write keeps bits, readback mirrors irqOut
        check("R9 R12 zero write", d, {16'h0, expS});
      end
    end

    // R5 R6 directed: pin 9 falling, pin 10 any transition
    for (int p = 0; p < 16; p++) styArr[p] = 3'd6;
    styArr[9] = 3'd3; styArr[10] = 3'd4;
    loadStyles();
    pinIn = 16'h0600;
    repeat (5) @(negedge clk);
    wr(2'd2, 32'hFFFF);
    pinIn = 16'h0000;
    repeat (4) @(negedge clk);
    check("R5 R6 falling", {16'h0, irqOut}, 32'h0600);
    wr(2'd2, 32'h0600);
    pinIn = 16'h0600;
    repeat (4) @(negedge clk);
    check("R5 R6 rising", {16'h0, irqOut}, 32'h0400);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule